// File: doc/BRIEF.md
# Match Timer with Clear Handshake

This block is a 32-bit up-counting event timer behind a small register port. The register port runs on the fast bus clock; the counter runs on a separate slow tick clock. Software stops the timer, loads a match value, clears the count, waits for the clear to land, and then enables counting. When the count equals the match value on an enabled tick, the block sends a one-cycle interrupt pulse. When clear-on-match is set, the count also returns to zero on that tick, which gives a periodic interrupt.

A clear request is carried into the tick domain by a toggle handshake. A status bit stays at 1 until the tick domain has zeroed the count and its acknowledge has come back. A second, free-running counter runs on the bus clock behind a prescaler that divides by 1 to 4. The register port is a plain single-cycle strobe interface with no back-pressure: a write takes effect on the clock edge that samples it, and read data appears one cycle after the read strobe.

The tick clock must be at least four times slower than the bus clock. Software changes the match value only while the timer is disabled. The shortest useful match value is 4 ticks.

Top module: `gp_match_timer`

## Requirements
- R1: After reset, the match (0x00), count (0x04), control (0x08), divider-select (0x10) and status (0x14) registers all read 0, and `irq` is low.
- R2: The match register reads back all 32 written bits. Control keeps bits [1:0] and divider-select keeps bits [1:0]; all other bits of these two registers read 0.
- R3: Any write to 0x0C zeroes the count, whatever the data. Status bit 10 reads 1 from the first read after such a write until the tick domain has acknowledged it, then reads 0.
- R4: While control bit 0 is 0, the count holds its value.
- R5: With control bits [1:0] = 2'b11 and match M, the count returns to 0 on the tick where it equals M. Interrupts then come exactly M+1 ticks apart, and the count never reads above M.
- R6: With control bits [1:0] = 2'b01, the count passes the match value and keeps counting. One interrupt is raised for that crossing.
- R7: Each match produces an `irq` pulse exactly one bus cycle wide, so software sees a rising edge.
- R8: The free-running counter at 0x18 advances by one every d bus cycles, where d = select + 1 for select codes 0, 1, 2 and 3.
- R9: A write to 0x10 that changes the select code restarts the prescaler. The first increment happens on the d-th bus edge after the write edge.
- R10: Writes to the count (0x04) and status (0x14) registers change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tclk | input | 1 | Slow tick clock that drives the event counter |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of `clk` |
| rd_en | input | 1 | Read strobe; `rdata` is valid on the next cycle |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | One-cycle match interrupt pulse |

## Verification
The periodic mode is run with random match values between 4 and 20. For each value the time between interrupt pulses must equal M+1 tick periods exactly, which separates a correct wrap-to-zero from an off-by-one reload. The one-shot mode is run with a small match value and a long enabled window, which separates "count passes the match and fires once" from a wrap or a repeated interrupt. The prescaler is run with random select codes and random gap lengths that are whole multiples of the period, and also with directed code changes read on every cycle. These separate a correct divide ratio from a correct restart phase.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int OFF_MATCH  = 'h00;
  localparam int OFF_COUNT  = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_CLEAR  = 'h0C;
  localparam int OFF_DIVSEL = 'h10;
  localparam int OFF_STATUS = 'h14;
  localparam int OFF_FREE   = 'h18;
  localparam int PEND_BIT   = 10;
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_WRAP  = 1;
endpackage

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [N];

  for (genvar g = 0; g < N; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/tmr_clr_xing.sv
`timescale 1ns/1ps
module tmr_clr_xing #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wr,
  output logic pend,
  input  logic tclk,
  output logic clr_evt
);
  logic req_tgl, ack_s, req_s, req_d;

  // request side, bus clock
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                req_tgl <= 1'b0;
    else if (clr_wr && !pend)  req_tgl <= ~req_tgl;

  assign pend = req_tgl ^ ack_s;

  // tick side
  tmr_sync #(.W(1), .N(N)) u_req_sync (
    .clk(tclk), .rst_n(rst_n), .d(req_tgl), .q(req_s));

  always_ff @(posedge tclk or negedge rst_n)
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_s;

  assign clr_evt = req_s ^ req_d;

  // acknowledge returns the toggle level already taken
  tmr_sync #(.W(1), .N(N)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(req_d), .q(ack_s));

  AST_PEND_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !pend) |=> pend); // R3
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
  parameter int CW = 32
) (
  input  logic          tclk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wrap,
  input  logic          clr_evt,
  input  logic [CW-1:0] match,
  output logic [CW-1:0] cnt,
  output logic          hit_tgl
);
  logic at_match;
  assign at_match = (cnt == match);

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hit_tgl <= 1'b0;
    end else if (clr_evt) begin
      cnt <= '0;
    end else if (run) begin
      if (at_match) begin
        hit_tgl <= ~hit_tgl;
        cnt     <= wrap ? '0 : cnt + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge tclk) disable iff (!rst_n)
    clr_evt |=> (cnt == '0)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge tclk) disable iff (!rst_n)
    (!run && !clr_evt) |=> $stable(cnt)); // R4
endmodule

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int CW = 32,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  input  logic          load,
  output logic [CW-1:0] value
);
  logic [SW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      value <= '0;
    end else if (load) begin
      phase <= '0;
    end else if (phase == sel) begin
      phase <= '0;
      value <= value + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(value) |-> (value == $past(value) + 1'b1)); // R8
endmodule

// File: rtl/gp_match_timer.sv
`timescale 1ns/1ps
module gp_match_timer
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int SW = 2;

  logic [DW-1:0] match_q;
  logic [1:0]    ctrl_q;
  logic [SW-1:0] div_q;
  logic          wr_match, wr_ctrl, wr_clear, wr_div, div_load;

  assign wr_match = wr_en && (addr == AW'(OFF_MATCH));
  assign wr_ctrl  = wr_en && (addr == AW'(OFF_CTRL));
  assign wr_clear = wr_en && (addr == AW'(OFF_CLEAR));
  assign wr_div   = wr_en && (addr == AW'(OFF_DIVSEL));
  assign div_load = wr_div && (wdata[SW-1:0] != div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      ctrl_q  <= '0;
      div_q   <= '0;
    end else begin
      if (wr_match) match_q <= wdata;
      if (wr_ctrl)  ctrl_q  <= wdata[1:0];
      if (wr_div)   div_q   <= wdata[SW-1:0];
    end
  end

  // clear handshake
  logic pend, clr_evt;
  tmr_clr_xing #(.N(SYNC_STAGES)) u_xing (
    .clk(clk), .rst_n(rst_n), .clr_wr(wr_clear), .pend(pend),
    .tclk(tclk), .clr_evt(clr_evt));

  // control bits into the tick domain
  logic [1:0] ctrl_t;
  tmr_sync #(.W(2), .N(SYNC_STAGES)) u_ctrl_sync (
    .clk(tclk), .rst_n(rst_n), .d(ctrl_q), .q(ctrl_t));

  logic [DW-1:0] cnt_t;
  logic          hit_tgl;
  tmr_core #(.CW(DW)) u_core (
    .tclk(tclk), .rst_n(rst_n), .run(ctrl_t[CTRL_RUN]), .wrap(ctrl_t[CTRL_WRAP]),
    .clr_evt(clr_evt), .match(match_q), .cnt(cnt_t), .hit_tgl(hit_tgl));

  // interrupt pulse back in the bus domain
  logic hit_s, hit_d, irq_q;
  tmr_sync #(.W(1), .N(SYNC_STAGES)) u_hit_sync (
    .clk(clk), .rst_n(rst_n), .d(hit_tgl), .q(hit_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hit_d <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hit_d <= hit_s;
      irq_q <= hit_s ^ hit_d;
    end
  assign irq = irq_q;

  // count readback: synchronize, then accept only two equal samples
  logic [DW-1:0] cnt_s, cnt_prev, cnt_rd;
  tmr_sync #(.W(DW), .N(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_t), .q(cnt_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_prev <= '0;
      cnt_rd   <= '0;
    end else begin
      cnt_prev <= cnt_s;
      if (cnt_s == cnt_prev) cnt_rd <= cnt_s;
    end

  // free-running counter
  logic [DW-1:0] free_cnt;
  tmr_prescale #(.CW(DW), .SW(SW)) u_free (
    .clk(clk), .rst_n(rst_n), .sel(div_q), .load(div_load), .value(free_cnt));

  // read mux
  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (addr == AW'(OFF_MATCH))       rd_val = match_q;
    else if (addr == AW'(OFF_COUNT))  rd_val = cnt_rd;
    else if (addr == AW'(OFF_CTRL))   rd_val[1:0] = ctrl_q;
    else if (addr == AW'(OFF_DIVSEL)) rd_val[SW-1:0] = div_q;
    else if (addr == AW'(OFF_STATUS)) rd_val[PEND_BIT] = pend;
    else if (addr == AW'(OFF_FREE))   rd_val = free_cnt;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
endmodule

// File: tb/gp_match_timer_bench.sv
`timescale 1ns/1ps
module gp_match_timer_bench;
  localparam int TCLK_NS = 40;

  logic clk = 0, tclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int checks = 0, errors = 0;
  int irq_n = 0, dbl_irq = 0;
  time t_last = 0, t_prev = 0;
  logic irq_prev = 0;

  always #2.5 clk = ~clk;
  initial begin #2; forever #(TCLK_NS/2) tclk = ~tclk; end

  gp_match_timer u_gp_match_timer (
    .clk(clk), .rst_n(rst_n), .tclk(tclk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        irq_n++;
        t_prev = t_last;
        t_last = $time;
        if (irq_prev) dbl_irq++;
      end
      irq_prev = irq;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  function automatic int period_ns(input int m);
    return (m + 1) * TCLK_NS;
  endfunction

  task automatic wait_clear(input string req);
    logic [31:0] s;
    bit done = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      bus_rd(5'h14, s);
      if (!s[10]) done = 1;
    end
    check(req, {31'b0, done}, 32'd1);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b, m;
    logic [31:0] smp [6];
    void'($urandom(32'd4711));
    repeat (10) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_rd(5'h00, v); check("R1 match", v, 0);
    bus_rd(5'h04, v); check("R1 count", v, 0);
    bus_rd(5'h08, v); check("R1 ctrl", v, 0);
    bus_rd(5'h10, v); check("R1 divsel", v, 0);
    bus_rd(5'h14, v); check("R1 status", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 readback
    m = $urandom;
    bus_wr(5'h00, m); bus_rd(5'h00, v); check("R2 match", v, m);
    bus_wr(5'h08, 32'hFFFF_FFFE); bus_rd(5'h08, v); check("R2 ctrl", v, 32'h2);
    bus_wr(5'h10, 32'hFFFF_FFF1); bus_rd(5'h10, v); check("R2 divsel", v, 32'h1);
    bus_wr(5'h08, 32'h0);

    // R3 clear with random data, pending flag
    bus_wr(5'h0C, $urandom);
    bus_rd(5'h14, v); check("R3 pending set", v, 32'h400);
    wait_clear("R3 pending drops");
    repeat (20) @(negedge clk);
    bus_rd(5'h04, v); check("R3 count zero", v, 0);

    // R10 writes to count and status ignored
    bus_wr(5'h04, 32'h55); bus_wr(5'h14, 32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    bus_rd(5'h04, v); check("R10 count write ignored", v, 0);
    bus_rd(5'h14, v); check("R10 status write ignored", v, 0);

    // R6 one-shot: count passes match, one interrupt
    bus_wr(5'h00, 32'd6);
    irq_n = 0;
    bus_wr(5'h08, 32'h1);
    repeat (30 * 8) @(negedge clk);
    bus_wr(5'h08, 32'h0);
    repeat (100) @(negedge clk);
    check("R6 single irq", irq_n, 1);
    bus_rd(5'h04, a);
    check("R6 count past match", {31'b0, a > 32'd6}, 1);
    // R4 frozen while disabled
    repeat (100) @(negedge clk);
    bus_rd(5'h04, b); check("R4 count held", b, a);

    // R5 periodic mode, random match values
    for (int it = 0; it < 4; it++) begin
      int mm;
      bit got;
      mm = $urandom_range(20, 4);
      bus_wr(5'h08, 32'h0);
      repeat (50) @(negedge clk);
      bus_wr(5'h00, mm);
      bus_wr(5'h0C, 32'h0);
      wait_clear("R3 pending drops");
      irq_n = 0;
      bus_wr(5'h08, 32'h3);
      got = 0;
      for (int w = 0; w < 20000 && !got; w++) begin
        @(negedge clk);
        if (irq_n >= 3) got = 1;
      end
      check("R5 irq seen", {31'b0, got}, 1);
      check("R5 period", 32'(t_last - t_prev), 32'(period_ns(mm)));
      bus_wr(5'h08, 32'h0);
      repeat (100) @(negedge clk);
      bus_rd(5'h04, v);
      check("R5 count bounded", {31'b0, v <= 32'(mm)}, 1);
    end

    // R8 divide ratio, random codes and gaps
    for (int it = 0; it < 5; it++) begin
      int code, k;
      code = $urandom_range(3, 0);
      k = $urandom_range(12, 3);
      bus_wr(5'h10, code);
      bus_rd(5'h18, a);
      repeat ((code + 1) * k - 1) @(negedge clk);
      bus_rd(5'h18, b);
      check("R8 free step", b - a, k);
    end

    // R9 restart phase on code change
    bus_wr(5'h10, 32'h0);
    repeat (7) @(negedge clk);
    for (int pass = 0; pass < 2; pass++) begin
      int d;
      d = (pass == 0) ? 4 : 2;
      bus_wr(5'h10, d - 1);
      for (int i = 0; i <= d; i++) bus_rd(5'h18, smp[i]);
      check("R9 hold before restart end", smp[d-1], smp[0]);
      check("R9 first step at d", smp[d], smp[0] + 1);
    end

    // R7 pulse width
    check("R7 one-cycle irq", dbl_irq, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule